// File: doc/BRIEF.md
# Word-to-Byte I/O Cycle Splitter

This block connects a processor-side I/O request port to a peripheral bus whose data path may be narrower than the processor word. Each request carries an 8-bit port number, a direction, a size flag (byte or 16-bit word) and, for writes, a 16-bit data word. A one-cycle start strobe launches the request. The block then runs one or two bus cycles and reports completion with a single-cycle done pulse.

A word occupies two neighbouring port numbers. The low byte belongs to port N and the high byte to port N+1. The parameter `BUS_W` sets the bus width. With an 8-bit bus (`BUS_W` = 8), a word becomes two consecutive bus cycles: port N first, then port N+1. With a 16-bit bus (`BUS_W` = 16), a word takes one cycle addressed to port N. Bytes always take a single cycle to port N. On a read, the returned bytes are assembled into `rdata_o`.

Top module: `io_split`

## Requirements
- R1: While `rst_ni` is low and after it rises, `busy_o`, `done_o`, `bus_wr_o` and `bus_rd_o` are 0, and `rdata_o` is 0.
- R2: With `BUS_W` = 8, a word request accepted at clock edge k drives a bus cycle in the clock period after edge k. That cycle carries port N and data bits 7:0. The next period carries port N+1 and data bits 15:8.
- R3: With `BUS_W` = 16, a word request makes exactly one bus cycle, to port N, carrying all 16 data bits.
- R4: A byte request makes exactly one bus cycle, to port N, carrying data bits 7:0. On a 16-bit bus, bus data bits 15:8 are 0.
- R5: With `BUS_W` = 8, the byte read in the first cycle fills `rdata_o[7:0]`, and the byte read in the second cycle fills `rdata_o[15:8]`. A byte read leaves `rdata_o[15:8]` at 0.
- R6: With `BUS_W` = 16, a word read loads all 16 bus bits into `rdata_o`. A byte read loads bus bits 7:0 and sets `rdata_o[15:8]` to 0.
- R7: `done_o` is high for exactly one cycle, in the period right after the last bus cycle. `rdata_o` holds its value until the next read updates it, and writes do not change it.
- R8: `busy_o` is high from the period after an accepted start through the done period. A start while `busy_o` is high is ignored.
- R9: The port number N+1 is computed modulo 256, so a word at port FFh uses port 00h for its high byte.
- R10: A write request (`write_i` = 1) strobes `bus_wr_o` in each of its bus cycles. A read request (`write_i` = 0) strobes `bus_rd_o`. No other strobe is asserted at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when not busy |
| write_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = 16-bit word, 0 = byte |
| port_i | input | 8 | Port number N |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Assembled read data |
| bus_addr_o | output | 8 | Bus port number |
| bus_wr_o | output | 1 | Bus write strobe |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_wdata_o | output | BUS_W | Bus write data |
| bus_rdata_i | input | BUS_W | Bus read data |

## Verification
The bench runs both bus widths side by side. Its peripheral returns data that depends on the address, so bytes assembled in the wrong lane or the wrong order show up in `rdata_o`. Word accesses at port FFh target the wrap case: a design that carries into a ninth bit, or reuses port N, shows the wrong address in the second cycle. Starts held high, or pulsed during a transfer, or during the done cycle, catch a design that restarts mid-transfer. They also catch a design that corrupts the latched request. Interleaved reads and writes show whether a write disturbs `rdata_o`, and whether done appears one cycle early or late.

// File: rtl/io_split_pkg.sv
package io_split_pkg;
  localparam int PORT_W = 8;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI, ST_FIN} st_e;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [WORD_W-1:0] wdata;
    logic              word;
    logic              write;
  } req_t;
endpackage

// File: rtl/io_split_ctrl.sv
module io_split_ctrl
  import io_split_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  req_t req_i,
  output req_t req_o,
  output st_e  st_o,
  output logic cyc_o,
  output logic hi_o
);
  localparam bit TWO_CYC = (BUS_W == BYTE_W);

  st_e  st_q;
  req_t req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      req_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          req_q <= req_i;
          st_q  <= ST_LO;
        end
        ST_LO:   st_q <= (TWO_CYC && req_q.word) ? ST_HI : ST_FIN;
        ST_HI:   st_q <= ST_FIN;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o = req_q;
  assign st_o  = st_q;
  assign cyc_o = (st_q == ST_LO) || (st_q == ST_HI);
  assign hi_o  = (st_q == ST_HI);

  // R8
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> $stable(req_q));
endmodule

// File: rtl/io_split_lane.sv
module io_split_lane
  import io_split_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  req_t              req_i,
  input  logic              cyc_i,
  input  logic              hi_i,
  output logic [PORT_W-1:0] bus_addr_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  output logic [BUS_W-1:0]  bus_wdata_o
);
  assign bus_addr_o = hi_i ? PORT_W'(req_i.port + 1'b1) : req_i.port;
  assign bus_wr_o   = cyc_i && req_i.write;
  assign bus_rd_o   = cyc_i && !req_i.write;

  generate
    if (BUS_W == BYTE_W) begin : g_narrow
      assign bus_wdata_o = hi_i ? req_i.wdata[WORD_W-1:BYTE_W] : req_i.wdata[BYTE_W-1:0];
    end else begin : g_wide
      assign bus_wdata_o = req_i.word ? req_i.wdata
                                      : {{(WORD_W-BYTE_W){1'b0}}, req_i.wdata[BYTE_W-1:0]};
    end
  endgenerate
endmodule

// File: rtl/io_split_asm.sv
module io_split_asm
  import io_split_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              hi_i,
  input  logic              word_i,
  input  logic [BUS_W-1:0]  bus_rdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] acc_q;

  generate
    if (BUS_W == BYTE_W) begin : g_narrow
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           acc_q <= '0;
        else if (rd_i && hi_i) acc_q[WORD_W-1:BYTE_W] <= bus_rdata_i;
        else if (rd_i)         acc_q <= {{(WORD_W-BYTE_W){1'b0}}, bus_rdata_i};
      end

      // R5
      hi_keeps_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && hi_i) |=> (acc_q[BYTE_W-1:0] == $past(acc_q[BYTE_W-1:0])));
    end else begin : g_wide
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   acc_q <= '0;
        else if (rd_i) acc_q <= word_i ? bus_rdata_i[WORD_W-1:0]
                                       : {{(WORD_W-BYTE_W){1'b0}}, bus_rdata_i[BYTE_W-1:0]};
      end
    end
  endgenerate

  assign rdata_o = acc_q;
endmodule

// File: rtl/io_split.sv
module io_split
  import io_split_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic              word_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [PORT_W-1:0] bus_addr_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  output logic [BUS_W-1:0]  bus_wdata_o,
  input  logic [BUS_W-1:0]  bus_rdata_i
);
  req_t req_in, req_q;
  st_e  st;
  logic cyc, hi, strobe;

  assign req_in = '{port: port_i, wdata: wdata_i, word: word_i, write: write_i};

  io_split_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .req_i(req_in),
    .req_o(req_q), .st_o(st), .cyc_o(cyc), .hi_o(hi)
  );

  io_split_lane #(.BUS_W(BUS_W)) u_lane (
    .req_i(req_q), .cyc_i(cyc), .hi_i(hi), .bus_addr_o(bus_addr_o),
    .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o), .bus_wdata_o(bus_wdata_o)
  );

  io_split_asm #(.BUS_W(BUS_W)) u_asm (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(bus_rd_o), .hi_i(hi),
    .word_i(req_q.word), .bus_rdata_i(bus_rdata_i), .rdata_o(rdata_o)
  );

  assign busy_o = (st != ST_IDLE);
  assign done_o = (st == ST_FIN);
  assign strobe = bus_wr_o || bus_rd_o;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_after_cyc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(strobe));
  // R8
  busy_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && strobe));
  // R10
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_wr_o, bus_rd_o}));

  generate
    if (BUS_W == BYTE_W) begin : g_chk_narrow
      // R9
      next_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe && $past(strobe)) |-> (bus_addr_o == PORT_W'($past(bus_addr_o) + 1'b1)));
    end else begin : g_chk_wide
      // R3
      single_cyc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe |=> !strobe);
    end
  endgenerate
endmodule

// File: tb/sim_io_split.sv
module sim_io_split;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic start = 1'b0, wr = 1'b0, word = 1'b0;
  logic [7:0] port = '0;
  logic [15:0] wd = '0;

  logic busy0, done0, bwr0, brd0, busy1, done1, bwr1, brd1;
  logic [15:0] rdata0, rdata1;
  logic [7:0] addr0, addr1, bwd0, brdata0;
  logic [15:0] bwd1, brdata1;

  int checks = 0, fails = 0;

  function automatic logic [7:0] p8(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction
  function automatic logic [15:0] p16(input logic [7:0] a);
    return {a ^ 8'hC3, a ^ 8'h5A};
  endfunction

  assign brdata0 = p8(addr0);
  assign brdata1 = p16(addr1);

  io_split #(.BUS_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .write_i(wr), .word_i(word),
    .port_i(port), .wdata_i(wd), .busy_o(busy0), .done_o(done0), .rdata_o(rdata0),
    .bus_addr_o(addr0), .bus_wr_o(bwr0), .bus_rd_o(brd0), .bus_wdata_o(bwd0),
    .bus_rdata_i(brdata0)
  );

  io_split #(.BUS_W(16)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .write_i(wr), .word_i(word),
    .port_i(port), .wdata_i(wd), .busy_o(busy1), .done_o(done1), .rdata_o(rdata1),
    .bus_addr_o(addr1), .bus_wr_o(bwr1), .bus_rd_o(brd1), .bus_wdata_o(bwd1),
    .bus_rdata_i(brdata1)
  );

  // reference model, index 0 = 8-bit bus, 1 = 16-bit bus
  int          m_rem [2];
  int          m_idx [2];
  logic        m_fin [2];
  logic [7:0]  m_port[2];
  logic [15:0] m_wd  [2];
  logic [15:0] m_acc [2];
  logic        m_word[2];
  logic        m_wr  [2];

  function automatic logic [7:0] m_addr(input int k);
    return 8'(m_port[k] + 8'(m_idx[k]));
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_ni) begin
        m_rem[k] = 0; m_idx[k] = 0; m_fin[k] = 1'b0; m_port[k] = '0;
        m_wd[k] = '0; m_acc[k] = '0; m_word[k] = 1'b0; m_wr[k] = 1'b0;
      end else if (m_fin[k]) begin
        m_fin[k] = 1'b0;
      end else if (m_rem[k] > 0) begin
        if (!m_wr[k]) begin
          logic [15:0] r;
          if (k == 0) begin
            r = {8'h00, p8(m_addr(k))};
            if (m_idx[k] == 0) m_acc[k] = r;
            else m_acc[k][15:8] = r[7:0];
          end else begin
            r = p16(m_addr(k));
            m_acc[k] = m_word[k] ? r : {8'h00, r[7:0]};
          end
        end
        m_rem[k]--;
        m_idx[k]++;
        if (m_rem[k] == 0) m_fin[k] = 1'b1;
      end else if (start) begin
        m_port[k] = port; m_wd[k] = wd; m_word[k] = word; m_wr[k] = wr;
        m_rem[k] = (word && k == 0) ? 2 : 1;
        m_idx[k] = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic act0, act1;
    act0 = m_rem[0] > 0;
    act1 = m_rem[1] > 0;
    if (!rst_ni) begin
      chk("R1 busy", {15'd0, busy0}, 16'd0);
      chk("R1 done", {15'd0, done1}, 16'd0);
      chk("R1 strobes", {12'd0, bwr0, brd0, bwr1, brd1}, 16'd0);
      chk("R1 rdata", rdata0 | rdata1, 16'd0);
    end else begin
      chk("R8 busy0", {15'd0, busy0}, {15'd0, act0 || m_fin[0]});
      chk("R8 busy1", {15'd0, busy1}, {15'd0, act1 || m_fin[1]});
      chk("R7 done0", {15'd0, done0}, {15'd0, m_fin[0]});
      chk("R7 done1", {15'd0, done1}, {15'd0, m_fin[1]});
      chk("R10 strobes0", {14'd0, bwr0, brd0}, {14'd0, act0 && m_wr[0], act0 && !m_wr[0]});
      chk("R10 strobes1", {14'd0, bwr1, brd1}, {14'd0, act1 && m_wr[1], act1 && !m_wr[1]});
      chk("R5 rdata0", rdata0, m_acc[0]);
      chk("R6 rdata1", rdata1, m_acc[1]);
      if (act0) begin
        chk(m_idx[0] == 1 ? "R2/R9 addr0 hi" : "R2 addr0", {8'd0, addr0}, {8'd0, m_addr(0)});
        if (m_wr[0])
          chk(m_word[0] ? "R2 wdata0" : "R4 wdata0", {8'd0, bwd0},
              {8'd0, m_idx[0] == 1 ? m_wd[0][15:8] : m_wd[0][7:0]});
      end
      if (act1) begin
        chk("R3 addr1", {8'd0, addr1}, {8'd0, m_addr(1)});
        if (m_wr[1])
          chk(m_word[1] ? "R3 wdata1" : "R4 wdata1", bwd1,
              m_word[1] ? m_wd[1] : {8'h00, m_wd[1][7:0]});
      end
    end
  end

  task automatic issue(input logic [7:0] p, input logic [15:0] d, input logic w, input logic wrt);
    @(negedge clk);
    port = p; wd = d; word = w; wr = wrt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_rem[0] > 0 || m_fin[0] || m_rem[1] > 0 || m_fin[1]) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    issue(8'h40, 16'h9876, 1'b1, 1'b1);   // R2 R3
    issue(8'h41, 16'h0000, 1'b1, 1'b0);   // R5 R6
    issue(8'h10, 16'h12AB, 1'b0, 1'b1);   // R4 R7 rdata kept
    issue(8'h20, 16'hFFFF, 1'b0, 1'b0);   // R5 R6 byte read
    issue(8'hFF, 16'hBEEF, 1'b1, 1'b1);   // R9
    issue(8'hFF, 16'h0000, 1'b1, 1'b0);   // R9 read
    // R8: start held high across busy and done periods
    @(negedge clk);
    port = 8'h30; wd = 16'hA1B2; word = 1'b1; wr = 1'b0; start = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      port = port + 8'h11; wd = wd ^ 16'h5555; wr = ~wr;
    end
    repeat (10) @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      start = ($urandom_range(0, 2) == 0);
      port  = 8'($urandom);
      wd    = 16'($urandom);
      word  = 1'($urandom);
      wr    = 1'($urandom);
    end
    start = 1'b0;
    repeat (6) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule